// File: doc/BRIEF.md
# Decode-Stage RAW Interlock with Register File

This block holds the operand register file of an in-order five-stage pipeline (fetch, decode, execute, memory, writeback) that has no bypass network. It also decides when an instruction sitting in decode must wait. Every operand is read from the register file during decode. If a source register still has a pending write from an older instruction in execute or memory, the block raises `stall`. The surrounding pipeline uses `stall` to freeze the program counter and the fetch/decode latch. At the same time the block puts an empty slot into the decode/execute position of its own destination-tag pipe.

The register file is write-first. A writeback to a register and a decode read of that register in the same cycle return the newly written value. For that reason an instruction in writeback never causes a wait. The wait depends only on how far behind its producer a consumer is: two cycles directly behind it, one cycle with a single instruction between them, and none beyond that. Loads and arithmetic producers are handled the same way, because neither can forward. Writes retire in program order, so there is no write-after-write check.

`stall` acts as back-pressure on the decode slot. While it is high, the upstream logic must hold every `dec_*` input unchanged. The slot is consumed on the first rising edge at which `dec_valid` is high and `stall` is low. `wb_data` is the result of the instruction currently in writeback, supplied by the datapath.

Top module: `raw_interlock`

## Requirements
- R1: While reset is held, `stall`, `ex_we` and `wb_we` are low, and both read ports return zero.
- R2: A consumer decoded in the cycle right after its producer sees `stall` high for exactly two cycles, then is accepted.
- R3: A consumer with one unrelated instruction between it and its producer sees `stall` high for exactly one cycle.
- R4: A consumer three slots behind its producer is never stalled, and its read port returns the `wb_data` being written that cycle.
- R5: Register index 0 never causes a stall, as a source or as a destination, and always reads as zero. Writes to index 0 are dropped.
- R6: A source whose valid flag is low, or a decode slot with `dec_valid` low, never causes a stall.
- R7: In each cycle after a stall cycle or an empty decode slot, the execute tag is empty (`ex_we` = 0, `ex_rd` = 0). The held instruction enters execute one cycle after `stall` falls.
- R8: Both source ports are checked: a match on the second source alone stalls exactly as a match on the first does.
- R9: The destination tag advances from execute to writeback in two cycles. The register file stores `wb_data` at the `wb_rd` index, and later reads return it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| dec_valid | input | 1 | An instruction occupies the decode slot |
| dec_rs1 | input | AW | First source register index |
| dec_rs1_vld | input | 1 | First source is a register read |
| dec_rs2 | input | AW | Second source register index |
| dec_rs2_vld | input | 1 | Second source is a register read |
| dec_rd | input | AW | Destination register index of the decoding instruction |
| dec_rd_we | input | 1 | Decoding instruction writes a register |
| wb_data | input | XLEN | Result of the instruction in writeback |
| stall | output | 1 | Hold fetch and decode; an empty slot enters execute |
| rs1_data | output | XLEN | First source operand read in decode |
| rs2_data | output | XLEN | Second source operand read in decode |
| ex_rd | output | AW | Destination index held in the execute tag |
| ex_we | output | 1 | Execute tag will write a register |
| wb_rd | output | AW | Destination index being written back |
| wb_we | output | 1 | Writeback writes a register this cycle |

## Verification
The directed patterns place a consumer at distances one, two and three behind a single producer. This separates the two-cycle wait, the one-cycle wait and the same-cycle write-first read, which would look the same if the window were off by one stage. Further patterns match only the second source, use register zero, clear a source valid flag, and leave the decode slot empty. Each of these would expose a missing qualifier in the comparators. A long pseudo-random stream over eight registers then produces back-to-back and overlapping dependences. A behavioural model checks it on every cycle for stall, operand values and tag movement.

// File: rtl/ri_pkg.sv
package ri_pkg;
  // default operand width and register count
  localparam int unsigned RI_XLEN_DEF = 32;
  localparam int unsigned RI_NREG_DEF = 32;
  // stages between decode and writeback whose writes are not yet visible
  localparam int unsigned RI_WIN_DEF  = 2;
  // read ports used by decode
  localparam int unsigned RI_NSRC_DEF = 2;
endpackage

// File: rtl/ri_regfile.sv
module ri_regfile #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned NREG = 32,
  parameter int unsigned NRD  = 2,
  parameter int unsigned AW   = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_idx,
  input  logic [XLEN-1:0] wr_data,
  input  logic [AW-1:0]   rd_idx  [NRD],
  output logic [XLEN-1:0] rd_data [NRD]
);
  logic [XLEN-1:0] mem [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(NREG); i++) mem[i] <= '0;
    end else if (wr_en && (wr_idx != '0)) begin
      mem[wr_idx] <= wr_data;
    end
  end

  // write-first: a same-cycle write wins over the stored word
  for (genvar p = 0; p < int'(NRD); p++) begin : g_rd
    always_comb begin
      if (rd_idx[p] == '0)
        rd_data[p] = '0;
      else if (wr_en && (wr_idx == rd_idx[p]))
        rd_data[p] = wr_data;
      else
        rd_data[p] = mem[rd_idx[p]];
    end
  end
endmodule

// File: rtl/ri_dst_pipe.sv
module ri_dst_pipe #(
  parameter int unsigned AW    = 5,
  parameter int unsigned DEPTH = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_we,
  input  logic [AW-1:0] in_rd,
  input  logic          bubble,
  output logic          tag_we [DEPTH],
  output logic [AW-1:0] tag_rd [DEPTH]
);
  for (genvar k = 0; k < int'(DEPTH); k++) begin : g_stage
    if (k == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          tag_we[k] <= 1'b0;
          tag_rd[k] <= '0;
        end else if (bubble) begin
          tag_we[k] <= 1'b0;
          tag_rd[k] <= '0;
        end else begin
          tag_we[k] <= in_we;
          tag_rd[k] <= in_rd;
        end
      end
    end else begin : g_body
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          tag_we[k] <= 1'b0;
          tag_rd[k] <= '0;
        end else begin
          tag_we[k] <= tag_we[k-1];
          tag_rd[k] <= tag_rd[k-1];
        end
      end
    end
  end
endmodule

// File: rtl/ri_hazard.sv
module ri_hazard #(
  parameter int unsigned AW   = 5,
  parameter int unsigned NSRC = 2,
  parameter int unsigned NWIN = 2
) (
  input  logic          dec_valid,
  input  logic [AW-1:0] src_idx [NSRC],
  input  logic          src_vld [NSRC],
  input  logic          win_we  [NWIN],
  input  logic [AW-1:0] win_rd  [NWIN],
  output logic          stall
);
  localparam int unsigned NHIT = NSRC * NWIN;
  logic [NHIT-1:0] hit;

  for (genvar s = 0; s < int'(NSRC); s++) begin : g_src
    for (genvar w = 0; w < int'(NWIN); w++) begin : g_win
      assign hit[s*NWIN + w] = src_vld[s] && (src_idx[s] != '0) &&
                               win_we[w] && (win_rd[w] == src_idx[s]);
    end
  end

  assign stall = dec_valid && (|hit);
endmodule

// File: rtl/raw_interlock.sv
module raw_interlock #(
  parameter int unsigned XLEN = ri_pkg::RI_XLEN_DEF,
  parameter int unsigned NREG = ri_pkg::RI_NREG_DEF,
  parameter int unsigned WIN  = ri_pkg::RI_WIN_DEF,
  parameter int unsigned AW   = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dec_valid,
  input  logic [AW-1:0]   dec_rs1,
  input  logic            dec_rs1_vld,
  input  logic [AW-1:0]   dec_rs2,
  input  logic            dec_rs2_vld,
  input  logic [AW-1:0]   dec_rd,
  input  logic            dec_rd_we,
  input  logic [XLEN-1:0] wb_data,
  output logic            stall,
  output logic [XLEN-1:0] rs1_data,
  output logic [XLEN-1:0] rs2_data,
  output logic [AW-1:0]   ex_rd,
  output logic            ex_we,
  output logic [AW-1:0]   wb_rd,
  output logic            wb_we
);
  localparam int unsigned NSRC  = ri_pkg::RI_NSRC_DEF;
  localparam int unsigned DEPTH = WIN + 1;
  localparam int unsigned WB_IX = WIN;
  localparam int unsigned LW_IX = WIN - 1;

  logic          tag_we [DEPTH];
  logic [AW-1:0] tag_rd [DEPTH];
  logic          win_we [WIN];
  logic [AW-1:0] win_rd [WIN];
  logic [AW-1:0] src_idx [NSRC];
  logic          src_vld [NSRC];
  logic [XLEN-1:0] src_data [NSRC];
  logic          bubble;
  logic          m_we;
  logic [AW-1:0] m_rd;

  assign src_idx[0] = dec_rs1;
  assign src_idx[1] = dec_rs2;
  assign src_vld[0] = dec_rs1_vld;
  assign src_vld[1] = dec_rs2_vld;

  for (genvar w = 0; w < int'(WIN); w++) begin : g_window
    assign win_we[w] = tag_we[w];
    assign win_rd[w] = tag_rd[w];
  end

  ri_hazard #(.AW(AW), .NSRC(NSRC), .NWIN(WIN)) u_hazard (
    .dec_valid (dec_valid),
    .src_idx   (src_idx),
    .src_vld   (src_vld),
    .win_we    (win_we),
    .win_rd    (win_rd),
    .stall     (stall)
  );

  assign bubble = stall || !dec_valid;

  ri_dst_pipe #(.AW(AW), .DEPTH(DEPTH)) u_pipe (
    .clk    (clk),
    .rst_n  (rst_n),
    .in_we  (dec_rd_we),
    .in_rd  (dec_rd),
    .bubble (bubble),
    .tag_we (tag_we),
    .tag_rd (tag_rd)
  );

  ri_regfile #(.XLEN(XLEN), .NREG(NREG), .NRD(NSRC), .AW(AW)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (tag_we[WB_IX]),
    .wr_idx  (tag_rd[WB_IX]),
    .wr_data (wb_data),
    .rd_idx  (src_idx),
    .rd_data (src_data)
  );

  assign rs1_data = src_data[0];
  assign rs2_data = src_data[1];
  assign ex_we    = tag_we[0];
  assign ex_rd    = tag_rd[0];
  assign m_we     = tag_we[LW_IX];
  assign m_rd     = tag_rd[LW_IX];
  assign wb_we    = tag_we[WB_IX];
  assign wb_rd    = tag_rd[WB_IX];
endmodule

// File: rtl/ri_checker.sv
module ri_checker #(
  parameter int unsigned AW   = 5,
  parameter int unsigned XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            dec_valid,
  input logic [AW-1:0]   rs1,
  input logic            rs1_vld,
  input logic [AW-1:0]   rs2,
  input logic            rs2_vld,
  input logic            stall,
  input logic            ex_we,
  input logic [AW-1:0]   ex_rd,
  input logic            m_we,
  input logic [AW-1:0]   m_rd,
  input logic            wb_we,
  input logic [AW-1:0]   wb_rd,
  input logic [XLEN-1:0] wb_data,
  input logic [XLEN-1:0] rs1_data,
  input logic [XLEN-1:0] rs2_data
);
  // R7: the slot after a stall carries no write
  a_r7_bubble_after_stall: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (!ex_we && ex_rd == '0));

  // R6: a stall needs an instruction with a live nonzero register source
  a_r6_stall_needs_source: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (dec_valid && ((rs1_vld && rs1 != '0) || (rs2_vld && rs2 != '0))));

  // R2: a stall needs a pending nonzero write in the window
  a_r2_stall_has_producer: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> ((ex_we && ex_rd != '0) || (m_we && m_rd != '0)));

  // R2: never more than two stall cycles in a row
  a_r2_bounded_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && $past(stall)) |=> !stall);

  // R5: register zero always reads zero
  a_r5_zero_read_a: assert property (@(posedge clk) disable iff (!rst_n)
    (rs1 == '0) |-> (rs1_data == '0));
  a_r5_zero_read_b: assert property (@(posedge clk) disable iff (!rst_n)
    (rs2 == '0) |-> (rs2_data == '0));

  // R4: a same-cycle writeback is what decode reads
  a_r4_write_first: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_we && wb_rd != '0 && wb_rd == rs1) |-> (rs1_data == wb_data));

  // R9: the execute tag reaches writeback two cycles later
  a_r9_tag_travel: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_we && $past(rst_n)) |=> ##1 (wb_we && wb_rd == $past(ex_rd, 2)));
endmodule

bind raw_interlock ri_checker #(.AW(AW), .XLEN(XLEN)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .dec_valid(dec_valid),
  .rs1      (dec_rs1),
  .rs1_vld  (dec_rs1_vld),
  .rs2      (dec_rs2),
  .rs2_vld  (dec_rs2_vld),
  .stall    (stall),
  .ex_we    (ex_we),
  .ex_rd    (ex_rd),
  .m_we     (m_we),
  .m_rd     (m_rd),
  .wb_we    (wb_we),
  .wb_rd    (wb_rd),
  .wb_data  (wb_data),
  .rs1_data (rs1_data),
  .rs2_data (rs2_data)
);

// File: tb/raw_interlock_test.sv
module raw_interlock_test;
  localparam int XLEN = 32;
  localparam int NREG = 32;
  localparam int AW   = 5;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            dec_valid = 1'b0;
  logic [AW-1:0]   dec_rs1 = '0;
  logic            dec_rs1_vld = 1'b0;
  logic [AW-1:0]   dec_rs2 = '0;
  logic            dec_rs2_vld = 1'b0;
  logic [AW-1:0]   dec_rd = '0;
  logic            dec_rd_we = 1'b0;
  logic [XLEN-1:0] wb_data = '0;
  logic            stall;
  logic [XLEN-1:0] rs1_data, rs2_data;
  logic [AW-1:0]   ex_rd, wb_rd;
  logic            ex_we, wb_we;

  int checks = 0;
  int fails  = 0;
  int tick   = 0;
  bit done   = 1'b0;

  // behavioural model state
  logic [XLEN-1:0] mrf [NREG];
  int  q_rd [3];
  bit  q_we [3];

  always #4 clk = ~clk;

  raw_interlock uut (
    .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid),
    .dec_rs1(dec_rs1), .dec_rs1_vld(dec_rs1_vld),
    .dec_rs2(dec_rs2), .dec_rs2_vld(dec_rs2_vld),
    .dec_rd(dec_rd), .dec_rd_we(dec_rd_we), .wb_data(wb_data),
    .stall(stall), .rs1_data(rs1_data), .rs2_data(rs2_data),
    .ex_rd(ex_rd), .ex_we(ex_we), .wb_rd(wb_rd), .wb_we(wb_we)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic bit pending(int r);
    return r != 0 && ((q_we[0] && q_rd[0] == r) || (q_we[1] && q_rd[1] == r));
  endfunction

  function automatic logic [XLEN-1:0] mread(int r);
    if (r == 0) return '0;
    if (q_we[2] && q_rd[2] == r) return wb_data;
    return mrf[r];
  endfunction

  // one clock: drive at negedge, compare, advance model across the posedge
  task automatic step(input bit v, input int r1, input bit v1, input int r2, input bit v2,
                      input int rd, input bit we, output bit st);
    bit es;
    dec_valid = v; dec_rs1 = AW'(r1); dec_rs1_vld = v1;
    dec_rs2 = AW'(r2); dec_rs2_vld = v2; dec_rd = AW'(rd); dec_rd_we = we;
    tick++;
    wb_data = 32'(tick) * 32'h9E37_79B1 + 32'h5;
    #2;
    es = v && ((v1 && pending(r1)) || (v2 && pending(r2)));
    chk(stall == es, "R2 R3 R6 R8 stall", stall, es);
    chk(rs1_data == mread(r1), "R4 R5 R9 rs1_data", rs1_data, mread(r1));
    chk(rs2_data == mread(r2), "R4 R5 R9 rs2_data", rs2_data, mread(r2));
    chk(ex_we == q_we[0] && int'(ex_rd) == q_rd[0], "R7 execute tag", {ex_we, ex_rd}, {q_we[0], 5'(q_rd[0])});
    chk(wb_we == q_we[2] && int'(wb_rd) == q_rd[2], "R9 writeback tag", {wb_we, wb_rd}, {q_we[2], 5'(q_rd[2])});
    if (q_we[2] && q_rd[2] != 0) mrf[q_rd[2]] = wb_data;
    q_we[2] = q_we[1]; q_rd[2] = q_rd[1];
    q_we[1] = q_we[0]; q_rd[1] = q_rd[0];
    if (es || !v) begin q_we[0] = 1'b0; q_rd[0] = 0; end
    else begin q_we[0] = we; q_rd[0] = rd; end
    st = es;
    @(negedge clk);
  endtask

  task automatic issue(input int r1, input bit v1, input int r2, input bit v2,
                       input int rd, input bit we, output int n);
    bit st;
    n = 0;
    do begin
      step(1'b1, r1, v1, r2, v2, rd, we, st);
      if (st) n++;
    end while (st);
  endtask

  task automatic idle(input int k);
    bit st;
    for (int i = 0; i < k; i++) step(1'b0, 0, 1'b0, 0, 1'b0, 0, 1'b0, st);
  endtask

  initial begin
    int n;
    bit st;
    int seed;
    for (int i = 0; i < NREG; i++) mrf[i] = '0;
    for (int i = 0; i < 3; i++) begin q_we[i] = 1'b0; q_rd[i] = 0; end
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(stall == 1'b0, "R1 stall", stall, 0);
    chk(ex_we == 1'b0 && wb_we == 1'b0, "R1 tags", {ex_we, wb_we}, 0);
    chk(rs1_data == '0 && rs2_data == '0, "R1 read ports", rs1_data, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: consumer right behind producer
    issue(0, 0, 0, 0, 1, 1, n);
    issue(1, 1, 0, 0, 3, 1, n);
    chk(n == 2, "R2 distance one waits", n, 2);
    idle(3);

    // R3: one unrelated instruction in between
    issue(0, 0, 0, 0, 2, 1, n);
    issue(9, 1, 0, 0, 7, 1, n);
    issue(2, 1, 0, 0, 4, 1, n);
    chk(n == 1, "R3 distance two waits", n, 1);
    idle(3);

    // R4: two unrelated in between, write-first read
    issue(0, 0, 0, 0, 5, 1, n);
    issue(0, 0, 0, 0, 12, 1, n);
    issue(0, 0, 0, 0, 13, 1, n);
    issue(5, 1, 0, 0, 6, 1, n);
    chk(n == 0, "R4 distance three no wait", n, 0);
    idle(3);

    // R5: register zero as destination and source
    issue(0, 0, 0, 0, 0, 1, n);
    issue(0, 1, 0, 1, 14, 1, n);
    chk(n == 0, "R5 zero register no wait", n, 0);
    idle(4);
    step(1'b0, 0, 1'b1, 0, 1'b0, 0, 1'b0, st);
    chk(rs1_data == '0, "R5 zero stays zero", rs1_data, 0);

    // R6: invalid source flag, then empty slot
    issue(0, 0, 0, 0, 10, 1, n);
    issue(10, 0, 10, 0, 15, 1, n);
    chk(n == 0, "R6 invalid source no wait", n, 0);
    step(1'b0, 10, 1'b1, 0, 1'b0, 0, 1'b0, st);
    chk(st == 1'b0, "R6 empty slot no wait", st, 0);
    idle(3);

    // R8: match on the second source only
    issue(0, 0, 0, 0, 11, 1, n);
    issue(3, 1, 11, 1, 16, 1, n);
    chk(n == 2, "R8 second source waits", n, 2);
    // R7: the held instruction is in execute right after acceptance
    chk(ex_we == 1'b1 && ex_rd == 5'd16, "R7 held instr enters execute", {ex_we, ex_rd}, {1'b1, 5'd16});
    idle(3);

    // pseudo-random stream over registers 0..7
    seed = 32'h1234_5677;
    for (int i = 0; i < 600; i++) begin
      seed = seed * 1103515245 + 12345;
      if (seed[3:0] == 4'd0) idle(1);
      else issue(int'(seed[10:8]), seed[4], int'(seed[14:12]), seed[5],
                 int'(seed[18:16]), seed[6] | seed[7], n);
    end
    idle(4);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=0", tick);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule